// File: doc/BRIEF.md
# Dual-Handshake Microprocessor Register Port

This block is the slave end of an 8-bit processor bus in front of a 64-entry register space. A static strap input picks one of two handshake styles for the same pins. With the strap low, the host uses a data strobe, a read/write direction line and an acknowledge output. With the strap high, the host uses separate read and write strobes and a ready output. The same output pin serves as acknowledge or ready, and it goes low when a transfer is done. A chip select and a 6-bit address qualify every access. Read data leaves on a shared 8-bit bus, and the block drives that bus only while a read is under way.

The host side runs without a clock. The chip select and both strobe lines are resynchronised into the core clock through a chain of flops. The block acts on an access once, on the cycle in which the synchronised strobe becomes active, however long the host holds the strobe. Two registers are implemented, and the rest of the space is left to the surrounding design. The first is an event status register: its bits are set by core-side event pulses, and a read clears the bits it returned. The second is a mask register. The active-low interrupt output is low whenever a status bit and its mask bit are both set. During reset the data bus floats, and the acknowledge and interrupt outputs stay high.

Top module: `regbus_dual_mode`

## Requirements
- R1: While reset is held, ack_n and irq_n are both 1.
- R2: With mode_i=0, a cycle with cs_n=0, ctl_n=0 (write) and strb_n falling to 0 writes data_io into the addressed register (mask register at address 0x01) and drives ack_n to 0.
- R3: With mode_i=0, a cycle with cs_n=0, ctl_n=1 (read) and strb_n at 0 drives the addressed register value onto data_io and drives ack_n to 0.
- R4: With mode_i=1, ctl_n at 0 (write strobe) with cs_n=0 writes data_io into the addressed register and drives ack_n to 0.
- R5: With mode_i=1, strb_n at 0 (read strobe) with cs_n=0 drives the addressed register value onto data_io and drives ack_n to 0.
- R6: Once the active strobe returns high, ack_n is back at 1 no later than the third clock edge, and the data bus is released at the same time.
- R7: A strobe held low for many cycles performs exactly one access. A status bit that arrives during a long status read is not cleared by that read.
- R8: With cs_n=1, strobes cause no ack and no register write.
- R9: Reading the status register (address 0x00) returns the latched event bits and clears exactly those bits. A second read with no new events returns 0x00.
- R10: irq_n is 0 exactly when (status & mask) is nonzero. Event bits whose mask bit is 0 leave irq_n at 1.
- R11: Addresses other than 0x00 and 0x01 read as 0x00 and ignore writes.
- R12: With mode_i=0, ctl_n at 0 while strb_n stays at 1 starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Handshake strap: 0 = strobe + direction + acknowledge, 1 = read strobe + write strobe + ready |
| cs_n | input | 1 | Active-low chip select |
| addr_i | input | 6 | Register address |
| strb_n | input | 1 | Data strobe (mode 0) or read strobe (mode 1), active low |
| ctl_n | input | 1 | Direction, 0 = write (mode 0), or write strobe (mode 1), active low |
| ack_n | output | 1 | Transfer complete (acknowledge or ready), active low |
| data_io | inout | 8 | Bidirectional data bus, bit 7 is the MSB |
| event_i | input | 8 | Core event pulses that set status bits |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default parameters: a 6-bit address, 8-bit data, a two-flop synchroniser, status at 0x00 and mask at 0x01. With those values, the acknowledge latency and the release window are short enough to check cycle-exactly in both handshake styles. A status read can be held long enough for an event to land mid-strobe, which shows that the access fires once per strobe. Masked and unmasked event bits, unselected strobes, a lone direction line in strobe mode and unmapped addresses are all observed through ack_n, irq_n and read-back values.

// File: rtl/regbus_dual_mode.sv
module regbus_dual_mode #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STAT_ADDR   = 0,
  parameter int MASK_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strb_n,
  input  logic              ctl_n,
  output logic              ack_n,
  inout  wire  [DATA_W-1:0] data_io,
  input  logic [DATA_W-1:0] event_i,
  output logic              irq_n
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] cs_sy, st_sy, ct_sy;
  logic          act_q, ack_q, rd_q;
  logic [DATA_W-1:0] stat_q, mask_q, rdat_q, rd_mux, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= '1;
      st_sy <= '1;
      ct_sy <= '1;
    end else begin
      cs_sy <= {cs_sy[LAST-1:0], cs_n};
      st_sy <= {st_sy[LAST-1:0], strb_n};
      ct_sy <= {ct_sy[LAST-1:0], ctl_n};
    end
  end

  wire cs_s  = cs_sy[LAST];
  wire st_s  = st_sy[LAST];
  wire ct_s  = ct_sy[LAST];
  wire act   = !cs_s && (mode_i ? (!st_s || !ct_s) : !st_s);
  wire start = act && !act_q;
  wire is_wr = !ct_s;
  wire hit_s = (addr_i == ADDR_W'(STAT_ADDR));
  wire hit_m = (addr_i == ADDR_W'(MASK_ADDR));

  assign rd_mux = hit_s ? stat_q : (hit_m ? mask_q : '0);
  assign clr    = (start && !is_wr && hit_s) ? stat_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ack_q  <= 1'b0;
      rd_q   <= 1'b0;
      rdat_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      act_q  <= act;
      stat_q <= (stat_q & ~clr) | event_i;
      if (start) begin
        ack_q <= 1'b1;
        rd_q  <= !is_wr;
        if (is_wr) begin
          if (hit_m) mask_q <= data_io;
        end else begin
          rdat_q <= rd_mux;
        end
      end else if (!act) begin
        ack_q <= 1'b0;
        rd_q  <= 1'b0;
      end
    end
  end

  assign ack_n   = !ack_q;
  assign data_io = (ack_q && rd_q) ? rdat_q : 'z;
  assign irq_n   = !(|(stat_q & mask_q));
endmodule

module regbus_dual_mode_chk #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_i,
  input logic              cs_n,
  input logic              strb_n,
  input logic              ctl_n,
  input logic              ack_n,
  input logic              irq_n,
  input logic [DATA_W-1:0] event_i
);
  localparam int CW = $clog2(SYNC_STAGES + 4) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] idle_cnt;
  logic          seen_ev;
  wire raw_act = !cs_n && (mode_i ? (!strb_n || !ctl_n) : !strb_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      seen_ev  <= 1'b0;
    end else begin
      if (raw_act) idle_cnt <= '0;
      else if (idle_cnt != CMAX) idle_cnt <= idle_cnt + 1'b1;
      if (|event_i) seen_ev <= 1'b1;
    end
  end

  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r1: assert (ack_n && irq_n);

  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt > CW'(SYNC_STAGES)) |-> ack_n);

  p_ack_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && raw_act) |=> !ack_n);

  p_ack_needs_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(!cs_n));

  p_irq_needs_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_ev |-> irq_n);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(ack_n) && ($past(event_i) == '0)) |-> $stable(irq_n));
endmodule

bind regbus_dual_mode regbus_dual_mode_chk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cs_n(cs_n), .strb_n(strb_n),
  .ctl_n(ctl_n), .ack_n(ack_n), .irq_n(irq_n), .event_i(event_i)
);

// File: tb/regbus_dual_mode_tb.sv
module regbus_dual_mode_tb;
  logic clk = 0, rst_n = 0, mode_i = 0, cs_n = 1, strb_n = 1, ctl_n = 1;
  logic [5:0] addr_i = '0;
  logic [7:0] event_i = '0, tb_d = '0;
  logic tb_oe = 0;
  wire  [7:0] data_io;
  logic ack_n, irq_n;
  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  event rd_ev;

  assign data_io = tb_oe ? tb_d : 'z;
  always #5 clk = ~clk;

  regbus_dual_mode u_dut (.clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cs_n(cs_n),
    .addr_i(addr_i), .strb_n(strb_n), .ctl_n(ctl_n), .ack_n(ack_n),
    .data_io(data_io), .event_i(event_i), .irq_n(irq_n));

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(rd_ev);
    begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(data_io === e, t, data_io, e);
    end
  end

  task automatic bus(input bit wr, input bit sel, input logic [5:0] a, input logic [7:0] d,
                     input logic [7:0] exp, input int hold, input logic [7:0] ev_mid, input string tag);
    int n;
    @(negedge clk);
    cs_n = !sel; addr_i = a;
    if (wr) begin tb_oe = 1; tb_d = d; end
    if (!mode_i) ctl_n = !wr;
    @(negedge clk);
    if (mode_i && wr) ctl_n = 0; else strb_n = 0;
    if (!sel) begin
      repeat (8) @(negedge clk);
      check(ack_n === 1'b1, {tag, " no ack unselected"}, {7'b0, ack_n}, 8'h01);
    end else begin
      n = 0;
      while (ack_n !== 1'b0 && n < 20) begin @(negedge clk); n++; end
      check(ack_n === 1'b0, {tag, " ack low"}, {7'b0, ack_n}, 8'h00);
      if (!wr) begin exp_q.push_back(exp); tag_q.push_back({tag, " read data"}); ->rd_ev; end
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        event_i = (i == 0) ? ev_mid : 8'h00;
      end
      event_i = 8'h00;
    end
    if (mode_i && wr) ctl_n = 1; else strb_n = 1;
    if (sel) begin
      repeat (3) @(negedge clk);
      check(ack_n === 1'b1, {tag, " R6 ack released"}, {7'b0, ack_n}, 8'h01);
    end
    cs_n = 1; ctl_n = 1; tb_oe = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] ev);
    @(negedge clk); event_i = ev;
    @(negedge clk); event_i = 8'h00;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ack_n === 1'b1 && irq_n === 1'b1, "R1 reset outputs", {6'b0, ack_n, irq_n}, 8'h03);
    rst_n = 1;
    repeat (2) @(negedge clk);

    bus(1, 1, 6'h01, 8'h0F, 8'h00, 0, 8'h00, "R2 mode0 write mask");
    bus(0, 1, 6'h01, 8'h00, 8'h0F, 0, 8'h00, "R3 mode0 read mask");
    bus(1, 1, 6'h20, 8'h55, 8'h00, 0, 8'h00, "R11 write unmapped");
    bus(0, 1, 6'h20, 8'h00, 8'h00, 0, 8'h00, "R11 read unmapped");
    bus(0, 1, 6'h01, 8'h00, 8'h0F, 0, 8'h00, "R11 mask untouched");
    bus(1, 0, 6'h01, 8'hFF, 8'h00, 0, 8'h00, "R8 unselected write");
    bus(0, 1, 6'h01, 8'h00, 8'h0F, 0, 8'h00, "R8 mask unchanged");

    @(negedge clk); cs_n = 0; addr_i = 6'h01; tb_oe = 1; tb_d = 8'hAA; ctl_n = 0;
    repeat (8) @(negedge clk);
    check(ack_n === 1'b1, "R12 direction alone no ack", {7'b0, ack_n}, 8'h01);
    cs_n = 1; ctl_n = 1; tb_oe = 0;
    repeat (2) @(negedge clk);
    bus(0, 1, 6'h01, 8'h00, 8'h0F, 0, 8'h00, "R12 mask unchanged");

    pulse(8'h80);
    check(irq_n === 1'b1, "R10 masked event no irq", {7'b0, irq_n}, 8'h01);
    pulse(8'h01);
    check(irq_n === 1'b0, "R10 unmasked event irq", {7'b0, irq_n}, 8'h00);
    bus(0, 1, 6'h00, 8'h00, 8'h81, 0, 8'h00, "R9 read status");
    check(irq_n === 1'b1, "R10 irq clears after read", {7'b0, irq_n}, 8'h01);
    bus(0, 1, 6'h00, 8'h00, 8'h00, 0, 8'h00, "R9 status cleared");

    pulse(8'h02);
    bus(0, 1, 6'h00, 8'h00, 8'h02, 10, 8'h04, "R7 long read");
    check(irq_n === 1'b0, "R7 mid-strobe event kept", {7'b0, irq_n}, 8'h00);
    bus(0, 1, 6'h00, 8'h00, 8'h04, 0, 8'h00, "R7 second read");

    mode_i = 1;
    repeat (2) @(negedge clk);
    bus(1, 1, 6'h01, 8'h3C, 8'h00, 0, 8'h00, "R4 mode1 write mask");
    bus(0, 1, 6'h01, 8'h00, 8'h3C, 0, 8'h00, "R5 mode1 read mask");
    pulse(8'h10);
    check(irq_n === 1'b0, "R10 mode1 irq", {7'b0, irq_n}, 8'h00);
    bus(0, 1, 6'h00, 8'h00, 8'h10, 0, 8'h00, "R5 mode1 read status");
    bus(1, 0, 6'h01, 8'h00, 8'h00, 0, 8'h00, "R8 mode1 unselected");
    bus(0, 1, 6'h01, 8'h00, 8'h3C, 0, 8'h00, "R8 mode1 mask kept");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule